// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits next to an instruction fetch unit and runs repeat loops with no branch instruction in the loop body. Software loads three values: the address of the first loop instruction, the address of the last loop instruction (with bit 0 acting as an arm flag), and a 12-bit repeat count. Each cycle the controller compares the address of the instruction now completing with the loop-end address. It then chooses the next fetch: the sequential address, the loop start, or a branch target. It also steps the count down once for each pass through the loop end.

The count drives a small state machine with three named states. `ST_OFF` holds while the count is zero, and the loop end then behaves as an ordinary instruction. `ST_MULTI` holds while the count is two or more, and the loop end then redirects to the loop start. `ST_FINAL` holds while the count is one, and the loop end then falls through. The transitions are OFF→MULTI and OFF→FINAL on a count load, MULTI→MULTI and MULTI→FINAL on a decrement, FINAL→OFF on the last decrement, and any state to any other state on a count load. A branch with no delay slot that sits at the loop end still consumes one count. When it is taken, control goes to its target.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset the visible count is 0 and `npc_sel` is 2'b00 (sequential).
- R2: A loop-end hit requires `end_q[0]==1` and `cur_pc[31:1]==end_q[31:1]`. Bit 0 of `cur_pc` takes no part in the comparison.
- R3: On `done` with a hit and a count of 2 or more, `npc_sel` is 2'b01 and `npc_target` is the loop-start register. The count is one lower after the clock edge.
- R4: On `done` with a hit and a count of 1, `npc_sel` is 2'b00 and `npc_target` is `cur_pc+4`. The count becomes 0.
- R5: With a count of 0, a hit on `done` gives `npc_sel` 2'b00 and the count stays 0.
- R6: On `done` with a hit, a nonzero count and `br_taken`, `npc_sel` is 2'b10 and `npc_target` is `br_target`. The count still drops by 1.
- R7: A not-taken branch at the loop end behaves like R3 and R4: it returns to the loop start when the count is 2 or more, and falls through when the count is 1.
- R8: A count load in the same cycle as a decrement wins. The count takes the loaded value `ld_data[11:0]`.
- R9: While `done` is low, `npc_sel` is 2'b00 and a matching address leaves the count unchanged.
- R10: A taken branch without a hit gives `npc_sel` 2'b10 and leaves the count unchanged.
- R11: Loads of the start and end registers take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc | input | 32 | Address of the instruction now completing |
| done | input | 1 | Instruction-complete strobe |
| ld_start | input | 1 | Write loop-start register |
| ld_end | input | 1 | Write loop-end register (bit 0 = arm) |
| ld_count | input | 1 | Write repeat count |
| ld_data | input | 32 | Write data for the three loads |
| br_taken | input | 1 | Completing instruction is a taken branch |
| br_target | input | 32 | Target of that branch |
| npc_sel | output | 2 | Next-PC source: 00 sequential, 01 loop start, 10 branch |
| npc_target | output | 32 | Next-PC address, valid while `done` is high |
| rpt_count | output | 12 | Current repeat count |

## Verification
Two events can land on the same cycle. A taken branch can complete exactly at the loop end, and a software count load can coincide with the decrement of a loop-end pass. The bench provokes the first by raising `br_taken` on a hit with a live count. It judges the result by the branch select and target together with a count that has still dropped by one. For the second, it raises `ld_count` on a decrementing hit and expects the loaded value, not the decremented one, after the edge.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
    typedef enum logic [1:0] {
        SEL_SEQ = 2'b00,
        SEL_RPT = 2'b01,
        SEL_BR  = 2'b10
    } npc_sel_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_MULTI = 2'd1,
        ST_FINAL = 2'd2
    } lp_state_t;
endpackage

// File: rtl/hwloop_match.sv
module hwloop_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] end_addr,
    output logic          hit
);
    // bit 0 of the end register is the arm flag; address bit 0 is ignored
    assign hit = end_addr[0] && (pc[AW-1:1] == end_addr[AW-1:1]);
endmodule

// File: rtl/hwloop_count.sv
module hwloop_count #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_next
);
    always_comb begin
        if (ld)       cnt_next = ld_val;
        else if (dec) cnt_next = cnt - 1'b1;
        else          cnt_next = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_next;
    end

    // R3/R4/R6: a decrement without a load lowers the count by exactly one
    p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !ld) |=> (cnt == $past(cnt) - 1'b1));
    // R8: a load always wins
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/hwloop_fsm.sv
module hwloop_fsm
    import hwloop_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic          hit,
    input  logic          br_taken,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_next,
    output npc_sel_t      sel,
    output logic          dec
);
    lp_state_t state, state_nx;

    always_comb begin
        if (cnt_next == '0)                   state_nx = ST_OFF;
        else if (cnt_next == {{(CW-1){1'b0}}, 1'b1}) state_nx = ST_FINAL;
        else                                  state_nx = ST_MULTI;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        sel = SEL_SEQ;
        dec = 1'b0;
        if (done) begin
            if (hit) begin
                unique case (state)
                    ST_OFF: begin
                        sel = br_taken ? SEL_BR : SEL_SEQ;
                    end
                    ST_MULTI: begin
                        dec = 1'b1;
                        sel = br_taken ? SEL_BR : SEL_RPT;
                    end
                    ST_FINAL: begin
                        dec = 1'b1;
                        sel = br_taken ? SEL_BR : SEL_SEQ;
                    end
                    default: begin
                        sel = SEL_SEQ;
                    end
                endcase
            end else begin
                sel = br_taken ? SEL_BR : SEL_SEQ;
            end
        end
    end

    // R5: a zero count never redirects to the loop start
    p_off_no_rpt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (sel != SEL_RPT));
    // R9: without the complete strobe the select stays sequential
    p_stall_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (sel == SEL_SEQ && !dec));
    // R4: a count of one never loops back
    p_final_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == {{(CW-1){1'b0}}, 1'b1}) |-> (sel != SEL_RPT));
endmodule

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 12,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cur_pc,
    input  logic          done,
    input  logic          ld_start,
    input  logic          ld_end,
    input  logic          ld_count,
    input  logic [AW-1:0] ld_data,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    output logic [1:0]    npc_sel,
    output logic [AW-1:0] npc_target,
    output logic [CW-1:0] rpt_count
);
    localparam logic [AW-1:0] INC = AW'(STEP);

    logic [AW-1:0] start_q, end_q;
    logic [CW-1:0] cnt, cnt_next;
    logic          hit, dec;
    npc_sel_t      sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else begin
            if (ld_start) start_q <= ld_data;
            if (ld_end)   end_q   <= ld_data;
        end
    end

    hwloop_match #(.AW(AW)) u_match (
        .pc       (cur_pc),
        .end_addr (end_q),
        .hit      (hit)
    );

    hwloop_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld_count),
        .ld_val   (ld_data[CW-1:0]),
        .dec      (dec),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    hwloop_fsm #(.CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .hit      (hit),
        .br_taken (br_taken),
        .cnt      (cnt),
        .cnt_next (cnt_next),
        .sel      (sel),
        .dec      (dec)
    );

    always_comb begin
        unique case (sel)
            SEL_RPT: npc_target = start_q;
            SEL_BR:  npc_target = br_target;
            default: npc_target = cur_pc + INC;
        endcase
    end

    assign npc_sel   = sel;
    assign rpt_count = cnt;

    // R3: a loop-start select always carries the start register
    p_rpt_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_sel == 2'b01) |-> (npc_target == start_q));
    // R10: a taken branch off the loop end leaves the count alone
    p_br_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && br_taken && !hit && !ld_count) |=> $stable(rpt_count));
endmodule

// File: tb/sim_hw_loop_ctrl.sv
`timescale 1ns/1ps
module sim_hw_loop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        done = 1'b0;
    logic        ld_start = 1'b0, ld_end = 1'b0, ld_count = 1'b0;
    logic [31:0] ld_data = '0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic [1:0]  npc_sel;
    logic [31:0] npc_target;
    logic [11:0] rpt_count;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    hw_loop_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .done(done),
        .ld_start(ld_start), .ld_end(ld_end), .ld_count(ld_count),
        .ld_data(ld_data), .br_taken(br_taken), .br_target(br_target),
        .npc_sel(npc_sel), .npc_target(npc_target), .rpt_count(rpt_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        done = 0; ld_start = 0; ld_end = 0; ld_count = 0; br_taken = 0;
    endtask

    task automatic write_reg(input int which, input logic [31:0] val);
        @(negedge clk);
        idle();
        ld_data = val;
        if (which == 0) ld_start = 1;
        else if (which == 1) ld_end = 1;
        else ld_count = 1;
        @(negedge clk);
        idle();
    endtask

    // drive one completing instruction, check comb outputs, then count after edge
    task automatic step(input string req, input logic [31:0] pc, input logic d,
                        input logic br, input logic [31:0] tgt,
                        input logic [1:0] exp_sel, input logic [31:0] exp_tgt,
                        input logic [11:0] exp_cnt);
        @(negedge clk);
        cur_pc = pc; done = d; br_taken = br; br_target = tgt;
        #1;
        check(req, {30'd0, npc_sel}, {30'd0, exp_sel});
        if (d) check(req, npc_target, exp_tgt);
        @(posedge clk);
        #1;
        check(req, {20'd0, rpt_count}, {20'd0, exp_cnt});
        idle();
    endtask

    task automatic t_reset();
        #1;
        check("R1", {20'd0, rpt_count}, 32'd0);
        check("R1", {30'd0, npc_sel}, 32'd0);
    endtask

    task automatic t_loop();
        write_reg(0, 32'h100);
        write_reg(1, 32'h10D);
        write_reg(2, 32'd3);
        step("R11", 32'h108, 1, 0, 0, 2'b00, 32'h10C, 12'd3);
        step("R3",  32'h10C, 1, 0, 0, 2'b01, 32'h100, 12'd2);
        step("R3",  32'h10C, 1, 0, 0, 2'b01, 32'h100, 12'd1);
        step("R4",  32'h10C, 1, 0, 0, 2'b00, 32'h110, 12'd0);
        step("R5",  32'h10C, 1, 0, 0, 2'b00, 32'h110, 12'd0);
    endtask

    task automatic t_bit0();
        write_reg(2, 32'd2);
        step("R2", 32'h10D, 1, 0, 0, 2'b01, 32'h100, 12'd1);
        write_reg(1, 32'h10C);
        write_reg(2, 32'd2);
        step("R2", 32'h10C, 1, 0, 0, 2'b00, 32'h110, 12'd2);
        write_reg(1, 32'h10D);
    endtask

    task automatic t_branch();
        write_reg(2, 32'd3);
        step("R6", 32'h10C, 1, 1, 32'h400, 2'b10, 32'h400, 12'd2);
        step("R7", 32'h10C, 1, 0, 32'h400, 2'b01, 32'h100, 12'd1);
        step("R7", 32'h10C, 1, 0, 32'h400, 2'b00, 32'h110, 12'd0);
        write_reg(2, 32'd1);
        step("R6", 32'h10C, 1, 1, 32'h480, 2'b10, 32'h480, 12'd0);
    endtask

    task automatic t_stall();
        write_reg(2, 32'd2);
        step("R9", 32'h10C, 0, 0, 0, 2'b00, 32'h0, 12'd2);
        step("R9", 32'h10C, 0, 1, 32'h400, 2'b00, 32'h0, 12'd2);
    endtask

    task automatic t_ldprio();
        write_reg(2, 32'd5);
        @(negedge clk);
        cur_pc = 32'h10C; done = 1; ld_count = 1; ld_data = 32'd9;
        #1;
        check("R8", {30'd0, npc_sel}, 32'd1);
        @(posedge clk);
        #1;
        check("R8", {20'd0, rpt_count}, 32'd9);
        idle();
    endtask

    task automatic t_br_off();
        write_reg(2, 32'd4);
        step("R10", 32'h200, 1, 1, 32'h600, 2'b10, 32'h600, 12'd4);
    endtask

    task automatic t_newstart();
        write_reg(0, 32'h240);
        step("R11", 32'h10C, 1, 0, 0, 2'b01, 32'h240, 12'd3);
    endtask

    initial begin
        fork
            begin
                t_reset();
                #22 rst_n = 1'b1;
                t_loop();
                t_bit0();
                t_branch();
                t_stall();
                t_ldprio();
                t_br_off();
                t_newstart();
            end
            begin
                #200000;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule